// File: doc/BRIEF.md
# Speculative Line Tracker with Commit Broadcast

This block sits beside one processor's data cache in a system where a transaction commits only at its end. It keeps two flags for every cache line. The speculative-read flag is set when the processor loads the line inside a transaction. The speculative-modified flag is set when the processor stores to the line. The modified flag is kept apart from the cache's own dirty bit. Each line that becomes modified for the first time has its line address appended to a small address buffer.

At the end of a transaction the processor asks to commit. The block raises a commit request and waits for a grant from an outside arbiter. It then sends the buffered line addresses back to back as one commit packet, marking the final address. Addresses that other processors broadcast when they commit arrive on a snoop port and are checked against the read flags. A match is a violation. The block then reports, in a single cycle, the set of modified lines that the cache must invalidate, and it clears every flag. If the cache would have to evict a line that is being tracked, or if the address buffer has no room for a new modified line, the block stalls the processor and requests a commit rather than lose speculative state.

Top module: `spec_track`

## Requirements
- R1: After reset no flag is set, the address buffer is empty, and `stall`, `commit_req`, `cmt_valid`, `cmt_last`, `commit_ok`, `viol` and `inv_mask` are all 0.
- R2: An access with `acc_valid`=1 and `stall`=0 is accepted on that clock edge. A load (`acc_we`=0) sets the read flag of `acc_addr`. A store (`acc_we`=1) sets the modified flag, and it appends `acc_addr` to the address buffer only if that line was not already modified. The buffer therefore holds each modified line once, in the order the lines were first stored.
- R3: A snoop (`snp_valid`=1) whose `snp_addr` has its read flag set causes `viol`=1 in the next cycle, for exactly one cycle. In that same cycle `inv_mask` bit i is 1 exactly for the lines modified before the rollback, and all flags and the buffer are cleared. A snoop that hits only a modified flag, or no flag, has no effect. `inv_mask` is 0 whenever `viol` is 0.
- R4: A commit starts when `cpu_commit`=1 while the block is idle. `commit_req` is 1 from the next cycle until the edge where `commit_grant`=1. In the cycles after that edge, `cmt_valid`=1 carries the buffered addresses on `cmt_addr`, one per cycle and in buffer order. `cmt_last` is 1 with the final address. `commit_ok` pulses for one cycle after the final address, and all flags and the buffer are cleared at that point.
- R5: A granted commit with an empty buffer sends no address, pulses `commit_ok` in the next cycle, and clears all flags.
- R6: The buffer holds DEPTH (16) addresses. A store to an unmodified line while the buffer is full drives `stall`=1 in that cycle. The store is not recorded, and `commit_req` is 1 from the next cycle.
- R7: `evict_valid`=1 for a line with its read or modified flag set drives `stall`=1 in that cycle and raises `commit_req` from the next cycle. An eviction of an untracked line has no effect.
- R8: A snoop hit while `commit_req` is 1 cancels the commit, even when the grant arrives in the same cycle. In the next cycle `commit_req`=0, `cmt_valid`=0 and `viol`=1.
- R9: Snoops are still checked while the packet is being sent. A hit drives `cmt_valid` to 0 in that cycle, stops the packet without a last marker, and rolls back as in R3.
- R10: `stall` is 1 whenever a commit is requested or being sent, and accesses offered then are not recorded.
- R11: When a snoop hit and an access occur in the same cycle, `stall` is 1, the rollback takes priority, and the access is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Speculative access offered |
| acc_we | input | 1 | 1 for store, 0 for load |
| acc_addr | input | LAW | Line address of the access |
| stall | output | 1 | Access not accepted this cycle |
| cpu_commit | input | 1 | Processor asks to end its transaction |
| evict_valid | input | 1 | Cache wants to evict a line |
| evict_addr | input | LAW | Line the cache wants to evict |
| commit_req | output | 1 | Request for the right to commit |
| commit_grant | input | 1 | Right to commit granted |
| cmt_valid | output | 1 | Commit packet address valid |
| cmt_addr | output | LAW | Commit packet line address |
| cmt_last | output | 1 | Final address of the packet |
| commit_ok | output | 1 | One-cycle pulse on a successful commit |
| snp_valid | input | 1 | Another processor's committed address valid |
| snp_addr | input | LAW | Another processor's committed line address |
| viol | output | 1 | One-cycle violation and rollback pulse |
| inv_mask | output | 2**LAW | Lines to invalidate, valid with viol |

## Verification
Two collisions get the most attention. The first is a snoop hit in the same cycle as a processor access. The bench offers a store to a new line together with a snoop of a line it read earlier. It expects `stall` high in that cycle and an `inv_mask` with no bit for the stored line. A later empty commit shows that the store left no trace. The second is a snoop hit in the same cycle as the commit grant, or in the middle of the packet. For these, the behavioural model predicts that the violation wins and the stream is cut. Every output is compared with the model on every clock.

// File: rtl/spec_track.sv
module spec_track #(
  parameter int LAW   = 6,
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_we,
  input  logic [LAW-1:0]        acc_addr,
  output logic                  stall,
  input  logic                  cpu_commit,
  input  logic                  evict_valid,
  input  logic [LAW-1:0]        evict_addr,
  output logic                  commit_req,
  input  logic                  commit_grant,
  output logic                  cmt_valid,
  output logic [LAW-1:0]        cmt_addr,
  output logic                  cmt_last,
  output logic                  commit_ok,
  input  logic                  snp_valid,
  input  logic [LAW-1:0]        snp_addr,
  output logic                  viol,
  output logic [(1<<LAW)-1:0]   inv_mask
);
  localparam int LINES = 1 << LAW;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW    = $clog2(DEPTH);

  typedef enum logic [1:0] {IDLE, REQ, SEND} st_t;
  st_t st;

  logic [LINES-1:0] rd_q, md_q;
  logic [LAW-1:0]   abuf [DEPTH];
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    ptr;

  logic hit, ovf, evh, take, new_md;

  assign hit    = snp_valid & rd_q[snp_addr];
  assign new_md = acc_we & ~md_q[acc_addr];
  assign ovf    = acc_valid & new_md & (cnt == CW'(DEPTH));
  assign evh    = evict_valid & (rd_q[evict_addr] | md_q[evict_addr]);
  assign stall  = (st != IDLE) | hit | ovf | evh;
  assign take   = acc_valid & ~stall;

  assign commit_req = (st == REQ);
  assign cmt_valid  = (st == SEND) & ~hit;
  assign cmt_addr   = abuf[ptr];
  assign cmt_last   = cmt_valid & (CW'(ptr) == cnt - CW'(1));

  always_ff @(posedge clk)
    if (take && new_md) abuf[cnt[PW-1:0]] <= acc_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      rd_q      <= '0;
      md_q      <= '0;
      cnt       <= '0;
      ptr       <= '0;
      viol      <= 1'b0;
      inv_mask  <= '0;
      commit_ok <= 1'b0;
    end else begin
      viol      <= 1'b0;
      inv_mask  <= '0;
      commit_ok <= 1'b0;
      if (hit) begin
        viol     <= 1'b1;
        inv_mask <= md_q;
        rd_q     <= '0;
        md_q     <= '0;
        cnt      <= '0;
        st       <= IDLE;
      end else begin
        case (st)
          IDLE: begin
            if (take) begin
              if (acc_we) begin
                md_q[acc_addr] <= 1'b1;
                if (new_md) cnt <= cnt + CW'(1);
              end else begin
                rd_q[acc_addr] <= 1'b1;
              end
            end
            if (cpu_commit || ovf || evh) st <= REQ;
          end
          REQ: begin
            if (commit_grant) begin
              ptr <= '0;
              if (cnt == '0) begin
                rd_q      <= '0;
                md_q      <= '0;
                commit_ok <= 1'b1;
                st        <= IDLE;
              end else begin
                st <= SEND;
              end
            end
          end
          SEND: begin
            if (cmt_last) begin
              rd_q      <= '0;
              md_q      <= '0;
              cnt       <= '0;
              commit_ok <= 1'b1;
              st        <= IDLE;
            end else begin
              ptr <= ptr + PW'(1);
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spec_track_chk.sv
module spec_track_chk #(
  parameter int LAW = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stall,
  input logic                commit_req,
  input logic                cmt_valid,
  input logic                cmt_last,
  input logic                commit_ok,
  input logic                viol,
  input logic [(1<<LAW)-1:0] inv_mask,
  input logic [(1<<LAW)-1:0] rd_q,
  input logic [(1<<LAW)-1:0] md_q
);
  // R4
  req_not_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> !commit_req);
  // R10
  req_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> stall);
  // R3
  clean_rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (rd_q == '0 && md_q == '0));
  // R3
  mask_only_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> inv_mask == '0);
  // R3
  single_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !viol);
  // R4
  last_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_last) |=> commit_ok);
  // R8
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(commit_req) && viol) |-> !cmt_valid);
endmodule

bind spec_track spec_track_chk #(.LAW(LAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .commit_req(commit_req),
  .cmt_valid(cmt_valid), .cmt_last(cmt_last), .commit_ok(commit_ok),
  .viol(viol), .inv_mask(inv_mask), .rd_q(rd_q), .md_q(md_q)
);

// File: tb/tb_spec_track.sv
`timescale 1ns/1ps
module tb_spec_track;
  localparam int LAW = 6;
  localparam int LINES = 1 << LAW;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_we = 0, cpu_commit = 0, evict_valid = 0;
  logic commit_grant = 0, snp_valid = 0;
  logic [LAW-1:0] acc_addr = 0, evict_addr = 0, snp_addr = 0;
  logic stall, commit_req, cmt_valid, cmt_last, commit_ok, viol;
  logic [LAW-1:0] cmt_addr;
  logic [LINES-1:0] inv_mask;

  always #4 clk = ~clk;

  spec_track #(.LAW(LAW), .DEPTH(DEPTH)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit mrd [LINES];
  bit mmd [LINES];
  int q[$];
  int mst, mptr;
  bit mviol, mok;
  logic [LINES-1:0] mmask;
  bit e_hit, e_ovf, e_evh, e_stall;

  task automatic comb_model();
    e_hit   = snp_valid && mrd[snp_addr];
    e_ovf   = acc_valid && acc_we && !mmd[acc_addr] && q.size() == DEPTH;
    e_evh   = evict_valid && (mrd[evict_addr] || mmd[evict_addr]);
    e_stall = (mst != 0) || e_hit || e_ovf || e_evh;
  endtask

  task automatic clear_model();
    foreach (mrd[i]) begin mrd[i] = 0; mmd[i] = 0; end
    q.delete();
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      clear_model(); mst = 0; mptr = 0; mviol = 0; mok = 0; mmask = '0;
    end else begin
      comb_model();
      mviol = 0; mok = 0; mmask = '0;
      if (e_hit) begin
        foreach (mmd[i]) mmask[i] = mmd[i];
        mviol = 1; clear_model(); mst = 0;
      end else if (mst == 0) begin
        if (acc_valid && !e_stall) begin
          if (acc_we) begin
            if (!mmd[acc_addr]) begin mmd[acc_addr] = 1; q.push_back(int'(acc_addr)); end
          end else mrd[acc_addr] = 1;
        end
        if (cpu_commit || e_ovf || e_evh) mst = 1;
      end else if (mst == 1) begin
        if (commit_grant) begin
          mptr = 0;
          if (q.size() == 0) begin clear_model(); mok = 1; mst = 0; end
          else mst = 2;
        end
      end else begin
        if (mptr == q.size() - 1) begin clear_model(); mok = 1; mst = 0; end
        else mptr++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      #2;
      comb_model();
      chk(stall == e_stall, "R10 stall", stall, e_stall);
      chk(commit_req == (mst == 1), "R4 commit_req", commit_req, mst == 1);
      chk(cmt_valid == (mst == 2 && !e_hit), "R9 cmt_valid", cmt_valid, mst == 2 && !e_hit);
      if (mst == 2 && !e_hit) begin
        chk(cmt_addr == q[mptr], "R2 cmt_addr", cmt_addr, q[mptr]);
        chk(cmt_last == (mptr == q.size() - 1), "R4 cmt_last", cmt_last, mptr == q.size() - 1);
      end
      chk(viol == mviol, "R3 viol", viol, mviol);
      chk(inv_mask == mmask, "R3 inv_mask", inv_mask, mmask);
      chk(commit_ok == mok, "R4 commit_ok", commit_ok, mok);
    end
  end

  // stimulus helpers
  int got[$];

  task automatic clr();
    acc_valid = 0; acc_we = 0; cpu_commit = 0; evict_valid = 0;
    commit_grant = 0; snp_valid = 0;
  endtask
  task automatic nxt(); @(negedge clk); clr(); #3; endtask
  task automatic ld(input int a);
    @(negedge clk); clr(); acc_valid = 1; acc_we = 0; acc_addr = LAW'(a);
  endtask
  task automatic st(input int a);
    @(negedge clk); clr(); acc_valid = 1; acc_we = 1; acc_addr = LAW'(a);
  endtask
  task automatic snoop(input int a);
    @(negedge clk); clr(); snp_valid = 1; snp_addr = LAW'(a);
  endtask
  task automatic ask(); @(negedge clk); clr(); cpu_commit = 1; endtask
  task automatic grant(); @(negedge clk); clr(); commit_grant = 1; endtask
  task automatic collect();
    got.delete();
    for (int i = 0; i < 40; i++) begin
      nxt();
      if (cmt_valid) begin
        got.push_back(int'(cmt_addr));
        if (cmt_last) begin nxt(); break; end
      end else break;
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    chk(!stall && !commit_req && !cmt_valid && !viol && !commit_ok && inv_mask == 0,
        "R1 reset outputs", {stall, commit_req, cmt_valid, viol, commit_ok}, 0);

    // R2 / R4: ordered packet without duplicates
    ld(3); ld(5); st(10); st(12); st(10); st(7);
    ask(); nxt();
    chk(commit_req == 1, "R4 request raised", commit_req, 1);
    nxt();
    grant(); collect();
    chk(got.size() == 3, "R2 packet length", got.size(), 3);
    if (got.size() == 3)
      chk(got[0] == 10 && got[1] == 12 && got[2] == 7, "R2 packet order",
          {got[0][7:0], got[1][7:0], got[2][7:0]}, 24'h0a0c07);
    chk(commit_ok == 1, "R4 commit_ok pulse", commit_ok, 1);

    // R3: read-flag hit rolls back, modified-only hit ignored
    ld(9); st(20); snoop(20); nxt();
    chk(viol == 0, "R3 modified-only snoop ignored", viol, 0);
    snoop(9); nxt();
    chk(viol == 1, "R3 violation", viol, 1);
    chk(inv_mask == (64'd1 << 20), "R3 rollback mask", inv_mask, 64'd1 << 20);
    snoop(9); nxt();
    chk(viol == 0, "R3 flags cleared", viol, 0);

    // R6: overflow
    for (int i = 0; i < DEPTH; i++) st(i);
    st(16); #3;
    chk(stall == 1, "R6 overflow stall", stall, 1);
    nxt();
    chk(commit_req == 1, "R6 overflow request", commit_req, 1);
    grant(); collect();
    chk(got.size() == DEPTH, "R6 packet holds DEPTH", got.size(), DEPTH);
    if (got.size() == DEPTH) chk(got[DEPTH-1] == 15, "R6 extra store not recorded", got[DEPTH-1], 15);

    // R7 + R5: eviction of tracked line, empty commit
    ld(33);
    @(negedge clk); clr(); evict_valid = 1; evict_addr = 34; #3;
    chk(stall == 0, "R7 untracked evict", stall, 0);
    @(negedge clk); clr(); evict_valid = 1; evict_addr = 33; #3;
    chk(stall == 1, "R7 tracked evict stall", stall, 1);
    nxt();
    chk(commit_req == 1, "R7 evict requests commit", commit_req, 1);
    grant(); collect();
    chk(got.size() == 0, "R5 empty packet", got.size(), 0);
    chk(commit_ok == 1, "R5 empty commit ok", commit_ok, 1);

    // R8: hit during request beats same-cycle grant
    ld(4); ask(); nxt();
    @(negedge clk); clr(); snp_valid = 1; snp_addr = 4; commit_grant = 1;
    nxt();
    chk(viol == 1 && commit_req == 0 && cmt_valid == 0, "R8 commit cancelled",
        {viol, commit_req, cmt_valid}, 3'b100);

    // R9: hit during send
    ld(2); st(30); st(31); st(32); ask(); nxt(); grant(); nxt();
    chk(cmt_valid == 1 && cmt_addr == 30, "R9 stream started", cmt_addr, 30);
    snoop(2); #3;
    chk(cmt_valid == 0, "R9 stream cut", cmt_valid, 0);
    nxt();
    chk(viol == 1 && inv_mask == ((64'd7) << 30), "R9 rollback mask", inv_mask, 64'd7 << 30);

    // R11 + R10
    ld(6);
    @(negedge clk); clr(); snp_valid = 1; snp_addr = 6; acc_valid = 1; acc_we = 1; acc_addr = 40; #3;
    chk(stall == 1, "R11 same-cycle stall", stall, 1);
    nxt();
    chk(viol == 1 && inv_mask == 0, "R11 access dropped", inv_mask, 0);
    ask(); nxt();
    st(41); #3;
    chk(stall == 1, "R10 stall while requesting", stall, 1);
    grant(); collect();
    chk(got.size() == 0, "R10 access ignored while requesting", got.size(), 0);

    repeat (3) nxt();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule